// File: doc/BRIEF.md
# Tag-Only Coherent Private Cache Timing Model

This block models a private cache for a multicore timing emulator. It stores no data. Each line keeps only an address tag and a coherence state. For every core request the model reports whether the access hits. It also reports the coherence traffic the access needs: a read-for-share, a read-for-ownership, an upgrade, or a notice that a dirty victim must be written back.

A second input port accepts snoop messages from the interconnect. A snoop can demote or invalidate a line, and a snoop that finds a dirty line raises its own writeback notice. The model advances only on cycles where the emulator's clock enable is high, so a host can step it one target cycle at a time. One parameter selects the data-side variant, which uses four coherence states and two state bits per line. The same parameter can select the instruction-side variant, which uses a single valid bit per line and is read-only.

Top module: `tcm_top`

## Requirements
- R1: After reset every line is Invalid and all output valid flags are low. The first read to any line therefore misses.
- R2: The low log2(LINE_BYTES) address bits are the byte offset, the next log2(LINES) bits are the line index, and the remaining bits are the tag (3/9/20 at the defaults). A request hits only when the stored tag equals the request tag and the line state is not Invalid. Offset bits never affect a hit.
- R3: A read miss raises cmd_valid with cmd_kind 0 (read-for-share) and cmd_addr equal to the line-aligned request address. The data-side variant installs the line as Exclusive.
- R4: A read hit raises rsp_hit, issues no coherence command and changes no state.
- R5: A write that hits Modified or Exclusive issues no command and leaves the line Modified. A write that hits Shared issues cmd_kind 2 (upgrade) and still reports rsp_hit. A write miss issues cmd_kind 1 (read-for-ownership). Every write leaves the line Modified.
- R6: When a miss replaces a Modified line, wb_valid rises in the same response as the command, with wb_addr set to the victim's line address. Replacing a clean line raises no writeback.
- R7: A snoop whose tag matches a valid line acts by kind. Kind 1 (invalidate) moves the line to Invalid. Kind 0 (read) moves Modified or Exclusive to Shared. A matching snoop on a Modified line raises snp_wb_valid with the line address. Kinds 2 and 3, non-matching tags and read snoops on Shared lines change nothing.
- R8: When a snoop and a request arrive in the same enabled cycle for the same index, the snoop takes effect first and the request is judged against the post-snoop state.
- R9: In a cycle with clk_en low, no line state, tag or output changes, whatever the request and snoop inputs carry.
- R10: With DATA_SIDE = 0, writes are ignored (no response, no command). A read miss installs the line as Shared, read snoops leave it valid, and only kind 0 commands are ever issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Target-cycle enable; the model advances only when high |
| req_valid | input | 1 | Core request present |
| req_addr | input | ADDR_W | Core request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| snp_valid | input | 1 | Snoop message present |
| snp_addr | input | ADDR_W | Snoop byte address |
| snp_kind | input | 2 | 0 read, 1 invalidate, 2/3 no effect |
| rsp_valid | output | 1 | A response for the last enabled request |
| rsp_hit | output | 1 | That request hit |
| rsp_write | output | 1 | That request was a write |
| cmd_valid | output | 1 | Coherence command issued |
| cmd_kind | output | 2 | 0 read-for-share, 1 read-for-ownership, 2 upgrade |
| cmd_addr | output | ADDR_W | Line address of the command |
| wb_valid | output | 1 | Dirty victim writeback notice |
| wb_addr | output | ADDR_W | Victim line address |
| snp_wb_valid | output | 1 | Snoop found a dirty line |
| snp_wb_addr | output | ADDR_W | Line address the snoop hit |

## Verification
The request path and the snoop path can act on the same line index in one enabled cycle, and the interesting cases are where their order matters. The bench provokes this on purpose in two ways. An invalidate plus a write to a dirty line must give both a snoop writeback and a read-for-ownership miss. A read snoop plus a write to a dirty line must give a snoop writeback and then an upgrade. A long pseudo-random sweep over a small eight-line configuration then steers about half its snoops onto the request's index. Each response is judged against a bench model that applies the snoop before the request.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  // Coherence state of one line; the encoding is also the stored form on the data side.
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  // Outgoing coherence request kinds; values appear on the cmd_kind port.
  typedef enum logic [1:0] {
    CMD_RDS  = 2'd0,
    CMD_RDX  = 2'd1,
    CMD_UPG  = 2'd2,
    CMD_NONE = 2'd3
  } coh_cmd_t;

  localparam logic [1:0] SNP_READ = 2'd0;
  localparam logic [1:0] SNP_INV  = 2'd1;

endpackage

// File: rtl/tcm_line_store.sv
module tcm_line_store
  import tcm_pkg::*;
#(
  parameter int IDX_W     = 9,
  parameter int TAG_W     = 20,
  parameter int DATA_SIDE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  // request-side port: read and full (tag + state) write
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output mesi_t            a_st,
  input  logic             wr_a_en,
  input  logic [TAG_W-1:0] wr_a_tag,
  input  mesi_t            wr_a_st,
  // snoop-side port: read and state-only write
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output mesi_t            b_st,
  input  logic             wr_b_en,
  input  mesi_t            wr_b_st
);

  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];

  // Tags need no reset: a line's tag is only consulted while its state is valid.
  always_ff @(posedge clk) begin
    if (en && wr_a_en) tag_q[a_idx] <= wr_a_tag;
  end

  assign a_tag = tag_q[a_idx];
  assign b_tag = tag_q[b_idx];

  // State storage width depends on the variant. Port a is written last,
  // so it wins when both ports target one index.
  generate
    if (DATA_SIDE != 0) begin : g_mesi
      logic [1:0] st_q [LINES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < LINES; i++) st_q[i] <= 2'(ST_I);
        end else if (en) begin
          if (wr_b_en) st_q[b_idx] <= 2'(wr_b_st);
          if (wr_a_en) st_q[a_idx] <= 2'(wr_a_st);
        end
      end

      assign a_st = mesi_t'(st_q[a_idx]);
      assign b_st = mesi_t'(st_q[b_idx]);
    end else begin : g_valid
      logic st_q [LINES];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < LINES; i++) st_q[i] <= 1'b0;
        end else if (en) begin
          if (wr_b_en) st_q[b_idx] <= (wr_b_st != ST_I);
          if (wr_a_en) st_q[a_idx] <= (wr_a_st != ST_I);
        end
      end

      assign a_st = st_q[a_idx] ? ST_S : ST_I;
      assign b_st = st_q[b_idx] ? ST_S : ST_I;
    end
  endgenerate

endmodule

// File: rtl/tcm_req_engine.sv
module tcm_req_engine
  import tcm_pkg::*;
#(
  parameter int TAG_W     = 20,
  parameter int DATA_SIDE = 1
) (
  input  logic             valid,
  input  logic             write,
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] cur_tag,
  input  mesi_t            cur_st,
  output logic             act,
  output logic             hit,
  output logic             issue,
  output coh_cmd_t         cmd,
  output logic             upd,
  output mesi_t            next_st,
  output logic             victim_wb
);

  function automatic logic line_match(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b,
                                      input mesi_t st);
    return (st != ST_I) && (a == b);
  endfunction

  // State a freshly filled line takes after a read miss.
  function automatic mesi_t fill_state();
    return (DATA_SIDE != 0) ? ST_E : ST_S;
  endfunction

  logic match;
  assign match = line_match(tag, cur_tag, cur_st);

  always_comb begin
    act       = 1'b0;
    hit       = 1'b0;
    issue     = 1'b0;
    cmd       = CMD_NONE;
    upd       = 1'b0;
    next_st   = cur_st;
    victim_wb = 1'b0;
    if (valid && !(write && DATA_SIDE == 0)) begin
      act = 1'b1;
      hit = match;
      if (!write) begin
        if (!match) begin
          issue     = 1'b1;
          cmd       = CMD_RDS;
          upd       = 1'b1;
          next_st   = fill_state();
          victim_wb = (cur_st == ST_M);
        end
      end else begin
        upd     = 1'b1;
        next_st = ST_M;
        if (match) begin
          if (cur_st == ST_S) begin
            issue = 1'b1;
            cmd   = CMD_UPG;
          end
        end else begin
          issue     = 1'b1;
          cmd       = CMD_RDX;
          victim_wb = (cur_st == ST_M);
        end
      end
    end
  end

endmodule

// File: rtl/tcm_snoop_engine.sv
module tcm_snoop_engine
  import tcm_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic             valid,
  input  logic [1:0]       kind,
  input  logic [TAG_W-1:0] tag,
  input  logic [TAG_W-1:0] cur_tag,
  input  mesi_t            cur_st,
  output logic             upd,
  output mesi_t            next_st,
  output logic             dirty_wb
);

  logic match;
  assign match = valid && (cur_st != ST_I) && (cur_tag == tag);

  always_comb begin
    upd      = 1'b0;
    next_st  = cur_st;
    dirty_wb = 1'b0;
    if (match) begin
      if (kind == SNP_INV) begin
        upd      = 1'b1;
        next_st  = ST_I;
        dirty_wb = (cur_st == ST_M);
      end else if (kind == SNP_READ && (cur_st == ST_M || cur_st == ST_E)) begin
        upd      = 1'b1;
        next_st  = ST_S;
        dirty_wb = (cur_st == ST_M);
      end
    end
  end

endmodule

// File: rtl/tcm_top.sv
module tcm_top
  import tcm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 8,
  parameter int DATA_SIDE  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_kind,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_write,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              snp_wb_valid,
  output logic [ADDR_W-1:0] snp_wb_addr
);

  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

  function automatic logic [IDX_W-1:0] addr_index(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i, {OFS_W{1'b0}}};
  endfunction

  logic unused_offset_bits;
  assign unused_offset_bits = ^{req_addr[OFS_W-1:0], snp_addr[OFS_W-1:0]};

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag;
  assign req_idx = addr_index(req_addr);
  assign req_tag = addr_tag(req_addr);
  assign snp_idx = addr_index(snp_addr);
  assign snp_tag = addr_tag(snp_addr);

  logic [TAG_W-1:0] a_tag, b_tag;
  mesi_t            a_st, b_st;

  logic  snp_upd, snp_dirty;
  mesi_t snp_next;

  logic     req_act, req_hit, req_issue, req_upd, req_victim;
  coh_cmd_t req_cmd;
  mesi_t    req_next, req_view_st;

  // Named events for the checker and for waveform reading.
  logic evt_same_line, evt_fill, evt_upgrade, evt_victim_wb, evt_snoop_wb;

  tcm_line_store #(
    .IDX_W     (IDX_W),
    .TAG_W     (TAG_W),
    .DATA_SIDE (DATA_SIDE)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (clk_en),
    .a_idx    (req_idx),
    .a_tag    (a_tag),
    .a_st     (a_st),
    .wr_a_en  (req_upd),
    .wr_a_tag (req_tag),
    .wr_a_st  (req_next),
    .b_idx    (snp_idx),
    .b_tag    (b_tag),
    .b_st     (b_st),
    .wr_b_en  (snp_upd),
    .wr_b_st  (snp_next)
  );

  tcm_snoop_engine #(
    .TAG_W (TAG_W)
  ) u_snoop (
    .valid    (snp_valid),
    .kind     (snp_kind),
    .tag      (snp_tag),
    .cur_tag  (b_tag),
    .cur_st   (b_st),
    .upd      (snp_upd),
    .next_st  (snp_next),
    .dirty_wb (snp_dirty)
  );

  // The snoop is ordered ahead of the request on a shared index.
  assign evt_same_line = snp_valid && req_valid && (snp_idx == req_idx);
  assign req_view_st   = (evt_same_line && snp_upd) ? snp_next : a_st;

  tcm_req_engine #(
    .TAG_W     (TAG_W),
    .DATA_SIDE (DATA_SIDE)
  ) u_req (
    .valid     (req_valid),
    .write     (req_write),
    .tag       (req_tag),
    .cur_tag   (a_tag),
    .cur_st    (req_view_st),
    .act       (req_act),
    .hit       (req_hit),
    .issue     (req_issue),
    .cmd       (req_cmd),
    .upd       (req_upd),
    .next_st   (req_next),
    .victim_wb (req_victim)
  );

  assign evt_fill      = req_issue && (req_cmd != CMD_UPG);
  assign evt_upgrade   = req_issue && (req_cmd == CMD_UPG);
  assign evt_victim_wb = req_victim;
  assign evt_snoop_wb  = snp_dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_write    <= 1'b0;
      cmd_valid    <= 1'b0;
      cmd_kind     <= 2'd0;
      cmd_addr     <= '0;
      wb_valid     <= 1'b0;
      wb_addr      <= '0;
      snp_wb_valid <= 1'b0;
      snp_wb_addr  <= '0;
    end else if (clk_en) begin
      rsp_valid    <= req_act;
      rsp_hit      <= req_act && req_hit;
      rsp_write    <= req_act && req_write;
      cmd_valid    <= req_issue;
      cmd_kind     <= req_issue ? 2'(req_cmd) : 2'd0;
      cmd_addr     <= line_base(req_tag, req_idx);
      wb_valid     <= evt_victim_wb;
      wb_addr      <= line_base(a_tag, req_idx);
      snp_wb_valid <= evt_snoop_wb;
      snp_wb_addr  <= line_base(snp_tag, snp_idx);
    end
  end

endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 9,
  parameter int OFS_W     = 3,
  parameter int DATA_SIDE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_write,
  input logic              cmd_valid,
  input logic [1:0]        cmd_kind,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wb_valid,
  input logic [ADDR_W-1:0] wb_addr,
  input logic              snp_wb_valid
);

  localparam int HI = ADDR_W - 1;
  localparam int TB = IDX_W + OFS_W;

  // R9
  frozen_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable({rsp_valid, rsp_hit, rsp_write, cmd_valid, cmd_kind, wb_valid, snp_wb_valid}));

  // R3
  read_share_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd0) |-> (rsp_valid && !rsp_hit && !rsp_write));

  // R5
  upgrade_on_shared_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd2) |-> (rsp_hit && rsp_write));

  // R5
  ownership_on_write_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1) |-> (rsp_write && !rsp_hit));

  // R4
  read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && !rsp_write) |-> (!cmd_valid && !wb_valid));

  // R6
  victim_same_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (cmd_valid && !rsp_hit &&
                  wb_addr[TB-1:OFS_W] == cmd_addr[TB-1:OFS_W] &&
                  wb_addr[HI:TB] != cmd_addr[HI:TB]));

  // R10
  iside_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (DATA_SIDE == 0 && (rsp_valid || cmd_valid)) |-> (!rsp_write && cmd_kind == 2'd0 && !wb_valid));

endmodule

bind tcm_top tcm_checker #(
  .ADDR_W    (ADDR_W),
  .IDX_W     (IDX_W),
  .OFS_W     (OFS_W),
  .DATA_SIDE (DATA_SIDE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clk_en       (clk_en),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_write    (rsp_write),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind),
  .cmd_addr     (cmd_addr),
  .wb_valid     (wb_valid),
  .wb_addr      (wb_addr),
  .snp_wb_valid (snp_wb_valid)
);

// File: tb/tb_tcm_top.sv
`timescale 1ns/1ps
module tb_tcm_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic [1:0]  snp_kind = '0;

  logic        rsp_valid, rsp_hit, rsp_write, cmd_valid, wb_valid, snp_wb_valid;
  logic [1:0]  cmd_kind;
  logic [31:0] cmd_addr, wb_addr, snp_wb_addr;

  logic        i_rsp_valid, i_rsp_hit, i_rsp_write, i_cmd_valid, i_wb_valid, i_snp_wb_valid;
  logic [1:0]  i_cmd_kind;
  logic [31:0] i_cmd_addr, i_wb_addr, i_snp_wb_addr;

  always #2 clk = ~clk;

  // Small configuration: 8 lines of 8 bytes -> offset [2:0], index [5:3], tag [31:6].
  tcm_top #(.LINES(8)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_kind(snp_kind),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_write(rsp_write),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr),
    .snp_wb_valid(snp_wb_valid), .snp_wb_addr(snp_wb_addr));

  tcm_top #(.LINES(8), .DATA_SIDE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_kind(snp_kind),
    .rsp_valid(i_rsp_valid), .rsp_hit(i_rsp_hit), .rsp_write(i_rsp_write),
    .cmd_valid(i_cmd_valid), .cmd_kind(i_cmd_kind), .cmd_addr(i_cmd_addr),
    .wb_valid(i_wb_valid), .wb_addr(i_wb_addr),
    .snp_wb_valid(i_snp_wb_valid), .snp_wb_addr(i_snp_wb_addr));

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // Bench model: state 0 I, 1 S, 2 E, 3 M.
  int          mst  [8];
  logic [25:0] mtag [8];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [103:0] act, input logic [103:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [103:0] observed();
    return {rsp_valid, rsp_valid & rsp_write, rsp_valid & rsp_hit,
            cmd_valid, cmd_valid ? cmd_kind : 2'd0, cmd_valid ? cmd_addr : 32'd0,
            wb_valid, wb_valid ? wb_addr : 32'd0,
            snp_wb_valid, snp_wb_valid ? snp_wb_addr : 32'd0};
  endfunction

  function automatic logic [31:0] mk(input int tag, input int idx, input int off);
    return 32'((tag << 6) | (idx << 3) | off);
  endfunction

  // One enabled cycle; expected values from the model, snoop applied before request.
  task automatic step(input bit rv, input logic [31:0] ra, input bit rw,
                      input bit sv, input logic [31:0] sa, input logic [1:0] sk,
                      input string req);
    logic erv = 0, erw = 0, ehit = 0, ecv = 0, ewb = 0, eswb = 0;
    logic [1:0]  ek = 0;
    logic [31:0] eca = 0, ewa = 0, esa = 0;
    logic [103:0] exp_v;
    if (sv) begin
      int si = int'(sa[5:3]);
      if (mst[si] != 0 && mtag[si] == sa[31:6]) begin
        if (sk == 2'd1) begin
          eswb = (mst[si] == 3); mst[si] = 0;
        end else if (sk == 2'd0 && mst[si] >= 2) begin
          eswb = (mst[si] == 3); mst[si] = 1;
        end
      end
      esa = {sa[31:3], 3'b000};
    end
    if (rv) begin
      int ri = int'(ra[5:3]);
      erv = 1; erw = rw;
      ehit = (mst[ri] != 0) && (mtag[ri] == ra[31:6]);
      eca = {ra[31:3], 3'b000};
      ewa = {mtag[ri], ra[5:3], 3'b000};
      if (!rw) begin
        if (!ehit) begin
          ecv = 1; ek = 2'd0; ewb = (mst[ri] == 3);
          mst[ri] = 2; mtag[ri] = ra[31:6];
        end
      end else if (ehit) begin
        if (mst[ri] == 1) begin ecv = 1; ek = 2'd2; end
        mst[ri] = 3;
      end else begin
        ecv = 1; ek = 2'd1; ewb = (mst[ri] == 3);
        mst[ri] = 3; mtag[ri] = ra[31:6];
      end
    end
    exp_v = {erv, erw, ehit, ecv, ecv ? ek : 2'd0, ecv ? eca : 32'd0,
             ewb, ewb ? ewa : 32'd0, eswb, eswb ? esa : 32'd0};
    req_valid = rv; req_addr = ra; req_write = rw;
    snp_valid = sv; snp_addr = sa; snp_kind = sk;
    clk_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clk_en = 1'b0; req_valid = 1'b0; snp_valid = 1'b0;
    check(observed() == exp_v, req, "response", observed(), exp_v);
  endtask

  task automatic check_i(input string req, input logic rv, input logic hit,
                         input logic cv, input logic [1:0] k);
    logic [103:0] a = 104'({i_rsp_valid, i_rsp_valid & i_rsp_hit, i_cmd_valid,
                            i_cmd_valid ? i_cmd_kind : 2'd0, i_snp_wb_valid});
    logic [103:0] e = 104'({rv, hit, cv, k, 1'b0});
    check(a == e, req, "iside", a, e);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h2468_ace1;
    logic [103:0] snap;
    for (int i = 0; i < 8; i++) begin mst[i] = 0; mtag[i] = '0; end
    repeat (3) @(negedge clk);
    check(observed() == '0, "R1", "in reset", observed(), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(observed() == '0, "R1", "after reset", observed(), '0);

    // R10 instruction-side variant, driven alongside the data side.
    step(1, mk(7,7,0), 1, 0, 0, 0, "R10");
    check_i("R10", 0, 0, 0, 2'd0);
    step(1, mk(7,7,0), 0, 0, 0, 0, "R10");
    check_i("R10", 1, 0, 1, 2'd0);
    step(1, mk(7,7,4), 0, 0, 0, 0, "R10");
    check_i("R10", 1, 1, 0, 2'd0);
    step(1, mk(7,7,0), 0, 1, mk(7,7,0), 2'd0, "R10");
    check_i("R10", 1, 1, 0, 2'd0);
    step(1, mk(7,7,0), 0, 1, mk(7,7,0), 2'd1, "R10");
    check_i("R10", 1, 0, 1, 2'd0);

    // R1 every fresh line misses; R3 read-for-share and Exclusive fill
    for (int i = 0; i < 7; i++) step(1, mk(0,i,0), 0, 0, 0, 0, "R1 R3");
    // R4 read hit, R2 offset ignored, tag distinguishes lines
    step(1, mk(0,0,0), 0, 0, 0, 0, "R4");
    step(1, mk(0,0,5), 0, 0, 0, 0, "R2");
    step(1, mk(1,0,0), 0, 0, 0, 0, "R2");
    // R5 silent E->M, upgrade from S, ownership on miss
    step(1, mk(0,1,0), 1, 0, 0, 0, "R5");
    step(0, 0, 0, 1, mk(0,2,0), 2'd0, "R7");
    step(1, mk(0,2,0), 1, 0, 0, 0, "R5");
    step(1, mk(2,3,0), 1, 0, 0, 0, "R5");
    // R6 dirty victim then clean victim
    step(1, mk(3,1,0), 0, 0, 0, 0, "R6");
    step(1, mk(4,1,0), 0, 0, 0, 0, "R6");
    // R7 snoop kinds
    step(1, mk(0,4,0), 1, 0, 0, 0, "R7");
    step(0, 0, 0, 1, mk(0,4,0), 2'd2, "R7");
    step(0, 0, 0, 1, mk(0,4,0), 2'd3, "R7");
    step(0, 0, 0, 1, mk(5,4,0), 2'd0, "R7");
    step(1, mk(0,4,0), 1, 0, 0, 0, "R7");
    step(0, 0, 0, 1, mk(0,4,0), 2'd0, "R7");
    step(0, 0, 0, 1, mk(0,4,0), 2'd0, "R7");
    step(0, 0, 0, 1, mk(0,4,0), 2'd1, "R7");
    step(1, mk(0,4,0), 0, 0, 0, 0, "R7");
    // R8 snoop and request meet on one line
    step(1, mk(0,5,0), 1, 0, 0, 0, "R8");
    step(1, mk(0,5,0), 1, 1, mk(0,5,0), 2'd1, "R8");
    step(1, mk(0,5,0), 1, 1, mk(0,5,0), 2'd0, "R8");
    // R9 freeze: line 6 to Shared, then hold stimulus with clk_en low
    step(0, 0, 0, 1, mk(0,6,0), 2'd0, "R9");
    snap = observed();
    req_valid = 1; req_addr = mk(0,6,0); req_write = 1;
    snp_valid = 1; snp_addr = mk(0,6,0); snp_kind = 2'd1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check(observed() == snap, "R9", "frozen outputs", observed(), snap);
    end
    req_valid = 0; snp_valid = 0;
    step(1, mk(0,6,0), 0, 0, 0, 0, "R9");
    step(1, mk(0,6,0), 1, 0, 0, 0, "R9");

    // Pseudo-random sweep, snoops steered onto the request index half the time.
    for (int n = 0; n < 800; n++) begin
      int ri, si;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      ri = int'(lf[2:0]);
      si = lf[3] ? ri : int'(lf[6:4]);
      step(lf[7], mk(int'(lf[8]), ri, int'(lf[11:9])), lf[12],
           lf[13], mk(int'(lf[14]), si, 0), lf[16:15], "R8 R5 R6 R7");
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule